// File: doc/BRIEF.md
# Inter-processor command mailbox

This block is a small register mailbox that sits between a host processor and an I/O processor. Each processor has its own simple register port (select, write strobe, address, write data, read data). Three 32-bit registers are visible to both sides. The request pointer is at byte offset 0x0. The doorbell flags register is at byte offset 0x4. The reply pointer is at byte offset 0x8. The register set repeats every 0x400 bytes, because only the low ten address bits are decoded.

To issue a command, the host writes the physical address of a command structure into the request pointer. It then sets bit 0 of the flags register to say that a request is ready. When the work is done, the I/O processor writes the same structure address into the reply pointer. It then writes the pattern 0x14 into the flags register, which sets flag bits 2 and 4.

Each flag bit belongs to one side. The owner sets its own bits, and the other side acknowledges them by writing a 1 to clear them. A level interrupt goes to each processor while the other side has something pending for it.

Top module: `mbox_ipc_mailbox`

## Requirements
- R1: After reset, the request pointer, flags and reply pointer all read 0 on both ports, and both interrupts are low.
- R2: A host write to offset 0x0 loads the request pointer from the next cycle on. An I/O-side write to offset 0x0 leaves it unchanged.
- R3: An I/O-side write to offset 0x8 loads the reply pointer from the next cycle on. A host write to offset 0x8 leaves it unchanged.
- R4: Flag bits 2 and 4 (mask 0x14) belong to the I/O side, and every other flag bit belongs to the host. When a side writes a 1 to one of its own bits at offset 0x4, that bit is set. A 0 leaves the bit as it is.
- R5: When a side writes a 1 at offset 0x4 to a bit owned by the other side, that bit is cleared. A side cannot clear its own bits.
- R6: When both ports write offset 0x4 in the same cycle, the set and clear effects of both writes are merged bit by bit. On a bit that one port sets and the other clears, the set wins.
- R7: irq_to_iop is high exactly while flag bit 0 (request ready) is set. It rises in the cycle after the host write that sets the bit.
- R8: irq_to_host is high exactly while flag bit 2 or flag bit 4 is set.
- R9: Only address bits [9:2] select a register, so the set repeats every 0x400 bytes and address bits [1:0] are ignored. Word indices other than 0, 1 and 2 read 0, and writes to them change nothing.
- R10: Reads have no side effect, and both ports read the same value at the same offset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host port select |
| h_wr | input | 1 | Host write strobe, valid with h_sel |
| h_addr | input | 16 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from h_addr |
| i_sel | input | 1 | I/O-side port select |
| i_wr | input | 1 | I/O-side write strobe, valid with i_sel |
| i_addr | input | 16 | I/O-side byte address |
| i_wdata | input | 32 | I/O-side write data |
| i_rdata | output | 32 | I/O-side read data, combinational from i_addr |
| irq_to_host | output | 1 | Reply pending toward the host |
| irq_to_iop | output | 1 | Request pending toward the I/O side |

## Verification
Both ports can update the flags register in the same clock cycle. In that case a new doorbell from one side coincides with an acknowledge from the other. The bench provokes this by driving both ports onto offset 0x4 in a single cycle with write data that overlaps. In one cycle each port sets a bit while the other port clears the same bit. In other cycles they touch disjoint bits or both clear. The flags value read back in the following cycle is judged against the bitwise merge with set winning, and the two interrupt levels are checked against it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_HOST = 0;
    localparam int PORT_IOP  = 1;

    typedef enum logic [1:0] {
        REG_REQ   = 2'd0,
        REG_FLAGS = 2'd1,
        REG_REPLY = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          which
);
    localparam int IDX_W = WIN_W - 2;
    localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((1 << WIN_W) - 1);

    logic [IDX_W-1:0] word_idx;

    // word index inside the mirrored window; byte lane bits dropped
    assign word_idx = IDX_W'((addr & WIN_MASK) >> 2);

    always_comb begin
        case (word_idx)
            IDX_W'(0): which = REG_REQ;
            IDX_W'(1): which = REG_FLAGS;
            IDX_W'(2): which = REG_REPLY;
            default:   which = REG_NONE;
        endcase
    end
endmodule

// File: rtl/mbox_read_mux.sv
module mbox_read_mux
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  reg_sel_e          which,
    input  logic [DATA_W-1:0] req_ptr,
    input  logic [DATA_W-1:0] flags,
    input  logic [DATA_W-1:0] reply_ptr,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        case (which)
            REG_REQ:   rdata = req_ptr;
            REG_FLAGS: rdata = flags;
            REG_REPLY: rdata = reply_ptr;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_flags_merge.sv
module mbox_flags_merge #(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] IOP_OWNED  = 'h14
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              iop_we,
    input  logic [DATA_W-1:0] iop_wdata,
    output logic [DATA_W-1:0] nxt
);
    logic [DATA_W-1:0] set_d;
    logic [DATA_W-1:0] clr_d;

    always_comb begin
        set_d = '0;
        clr_d = '0;
        if (host_we) begin
            set_d = set_d | (host_wdata & ~IOP_OWNED);
            clr_d = clr_d | (host_wdata &  IOP_OWNED);
        end
        if (iop_we) begin
            set_d = set_d | (iop_wdata &  IOP_OWNED);
            clr_d = clr_d | (iop_wdata & ~IOP_OWNED);
        end
        // clear first, then set: a set on the same bit wins
        nxt = (cur & ~clr_d) | set_d;
    end
endmodule

// File: rtl/mbox_ipc_mailbox.sv
module mbox_ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 16,
    parameter int                WIN_W      = 10,
    parameter int                REQ_BIT    = 0,
    parameter logic [DATA_W-1:0] REPLY_MASK = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_sel,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              i_sel,
    input  logic              i_wr,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic [DATA_W-1:0] i_wdata,
    output logic [DATA_W-1:0] i_rdata,
    output logic              irq_to_host,
    output logic              irq_to_iop
);
    typedef struct packed {
        logic [DATA_W-1:0] req;
        logic [DATA_W-1:0] flags;
        logic [DATA_W-1:0] reply;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
    logic [NUM_PORTS-1:0]             p_we;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_rdata;
    reg_sel_e                         p_which [NUM_PORTS];

    logic [DATA_W-1:0] flags_nxt;
    logic              host_flags_we;
    logic              iop_flags_we;

    assign p_addr[PORT_HOST] = h_addr;
    assign p_addr[PORT_IOP]  = i_addr;
    assign p_we[PORT_HOST]   = h_sel & h_wr;
    assign p_we[PORT_IOP]    = i_sel & i_wr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbox_port_decode #(
            .ADDR_W (ADDR_W),
            .WIN_W  (WIN_W)
        ) u_dec (
            .addr  (p_addr[p]),
            .which (p_which[p])
        );

        mbox_read_mux #(
            .DATA_W (DATA_W)
        ) u_rd (
            .which     (p_which[p]),
            .req_ptr   (state_q.req),
            .flags     (state_q.flags),
            .reply_ptr (state_q.reply),
            .rdata     (p_rdata[p])
        );
    end

    assign h_rdata = p_rdata[PORT_HOST];
    assign i_rdata = p_rdata[PORT_IOP];

    assign host_flags_we = p_we[PORT_HOST] && (p_which[PORT_HOST] == REG_FLAGS);
    assign iop_flags_we  = p_we[PORT_IOP]  && (p_which[PORT_IOP]  == REG_FLAGS);

    mbox_flags_merge #(
        .DATA_W    (DATA_W),
        .IOP_OWNED (REPLY_MASK)
    ) u_merge (
        .cur        (state_q.flags),
        .host_we    (host_flags_we),
        .host_wdata (h_wdata),
        .iop_we     (iop_flags_we),
        .iop_wdata  (i_wdata),
        .nxt        (flags_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = flags_nxt;
        if (p_we[PORT_HOST] && (p_which[PORT_HOST] == REG_REQ)) begin
            state_d.req = h_wdata;
        end
        if (p_we[PORT_IOP] && (p_which[PORT_IOP] == REG_REPLY)) begin
            state_d.reply = i_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_to_iop  = state_q.flags[REQ_BIT];
    assign irq_to_host = |(state_q.flags & REPLY_MASK);

endmodule

// File: rtl/mbox_ipc_mailbox_chk.sv
module mbox_ipc_mailbox_chk #(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 16,
    parameter int                WIN_W      = 10,
    parameter int                REQ_BIT    = 0,
    parameter logic [DATA_W-1:0] REPLY_MASK = 'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_sel,
    input logic              h_wr,
    input logic [ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0] h_wdata,
    input logic              i_sel,
    input logic              i_wr,
    input logic [ADDR_W-1:0] i_addr,
    input logic [DATA_W-1:0] i_wdata,
    input logic              irq_to_host,
    input logic              irq_to_iop,
    input logic [DATA_W-1:0] req_q,
    input logic [DATA_W-1:0] flags_q,
    input logic [DATA_W-1:0] reply_q
);
    localparam int IDX_W = WIN_W - 2;
    localparam logic [ADDR_W-1:0] WMASK = ADDR_W'((1 << WIN_W) - 1);

    logic [IDX_W-1:0] h_word;
    logic [IDX_W-1:0] i_word;
    logic             h_w;
    logic             i_w;

    assign h_word = IDX_W'((h_addr & WMASK) >> 2);
    assign i_word = IDX_W'((i_addr & WMASK) >> 2);
    assign h_w    = h_sel && h_wr;
    assign i_w    = i_sel && i_wr;

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (req_q == '0 && flags_q == '0 && reply_q == '0));

    a_r2_req_load: assert property (@(posedge clk) disable iff (!rst_n)
        (h_w && h_word == IDX_W'(0)) |=> (req_q == $past(h_wdata)));

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_w && h_word == IDX_W'(0)) |=> $stable(req_q));

    a_r3_reply_load: assert property (@(posedge clk) disable iff (!rst_n)
        (i_w && i_word == IDX_W'(2)) |=> (reply_q == $past(i_wdata)));

    a_r3_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_w && i_word == IDX_W'(2)) |=> $stable(reply_q));

    a_r5_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[REQ_BIT] && !(i_w && i_word == IDX_W'(1))) |=> flags_q[REQ_BIT]);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (h_w && h_word == IDX_W'(1) && h_wdata[REQ_BIT] &&
         i_w && i_word == IDX_W'(1) && i_wdata[REQ_BIT]) |=> flags_q[REQ_BIT]);

    a_r7_iop_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (h_w && h_word == IDX_W'(1) && h_wdata[REQ_BIT]) |=> irq_to_iop);

    a_r8_host_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (i_w && i_word == IDX_W'(1) && (|(i_wdata & REPLY_MASK))) |=> irq_to_host);

endmodule

bind mbox_ipc_mailbox mbox_ipc_mailbox_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .WIN_W      (WIN_W),
    .REQ_BIT    (REQ_BIT),
    .REPLY_MASK (REPLY_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_sel       (h_sel),
    .h_wr        (h_wr),
    .h_addr      (h_addr),
    .h_wdata     (h_wdata),
    .i_sel       (i_sel),
    .i_wr        (i_wr),
    .i_addr      (i_addr),
    .i_wdata     (i_wdata),
    .irq_to_host (irq_to_host),
    .irq_to_iop  (irq_to_iop),
    .req_q       (state_q.req),
    .flags_q     (state_q.flags),
    .reply_q     (state_q.reply)
);

// File: tb/mbox_ipc_mailbox_bench.sv
module mbox_ipc_mailbox_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_sel = 1'b0, h_wr = 1'b0;
    logic [15:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        i_sel = 1'b0, i_wr = 1'b0;
    logic [15:0] i_addr = '0;
    logic [31:0] i_wdata = '0;
    logic [31:0] h_rdata, i_rdata;
    logic        irq_to_host, irq_to_iop;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // kind: 0 host rdata, 1 iop rdata, 2 irq_to_host, 3 irq_to_iop
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbox_ipc_mailbox u_mbox_ipc_mailbox (
        .clk (clk), .rst_n (rst_n),
        .h_sel (h_sel), .h_wr (h_wr), .h_addr (h_addr), .h_wdata (h_wdata), .h_rdata (h_rdata),
        .i_sel (i_sel), .i_wr (i_wr), .i_addr (i_addr), .i_wdata (i_wdata), .i_rdata (i_rdata),
        .irq_to_host (irq_to_host), .irq_to_iop (irq_to_iop)
    );

    // one task call = one clock cycle of stimulus
    task automatic drive(input logic hs, input logic hw, input logic [15:0] ha, input logic [31:0] hd,
                         input logic is, input logic iw, input logic [15:0] ia, input logic [31:0] id);
        @(negedge clk);
        h_sel = hs; h_wr = hw; h_addr = ha; h_wdata = hd;
        i_sel = is; i_wr = iw; i_addr = ia; i_wdata = id;
    endtask

    task automatic h_write(input logic [15:0] a, input logic [31:0] d);
        drive(1, 1, a, d, 0, 0, '0, '0);
    endtask

    task automatic i_write(input logic [15:0] a, input logic [31:0] d);
        drive(0, 0, '0, '0, 1, 1, a, d);
    endtask

    task automatic both_write(input logic [31:0] hd, input logic [31:0] id);
        drive(1, 1, 16'h0004, hd, 1, 1, 16'h0004, id);
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic expect_rd(input int port, input logic [15:0] a, input logic [31:0] exp, input string tag);
        if (port == 0) drive(1, 0, a, '0, 0, 0, '0, '0);
        else           drive(0, 0, '0, '0, 1, 0, a, '0);
        push(port, exp, tag);
    endtask

    task automatic expect_both(input logic [15:0] a, input logic [31:0] exp, input string tag);
        drive(1, 0, a, '0, 1, 0, a, '0);
        push(0, exp, tag);
        push(1, exp, tag);
    endtask

    task automatic expect_irqs(input logic eh, input logic ei, input string tag);
        drive(0, 0, '0, '0, 0, 0, '0, '0);
        push(2, {31'b0, eh}, tag);
        push(3, {31'b0, ei}, tag);
    endtask

    // monitor: compare queued expectations just after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0:       act = h_rdata;
                    1:       act = i_rdata;
                    2:       act = {31'b0, irq_to_host};
                    default: act = {31'b0, irq_to_iop};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        expect_rd(0, 16'h0000, 32'h0, "R1 req after reset");
        expect_rd(0, 16'h0004, 32'h0, "R1 flags after reset");
        expect_rd(1, 16'h0008, 32'h0, "R1 reply after reset");
        expect_irqs(0, 0, "R1 irqs after reset");

        // R2 request pointer, owned by host
        h_write(16'h0000, 32'h1234_5670);
        expect_rd(0, 16'h0000, 32'h1234_5670, "R2 host loads req");
        i_write(16'h0000, 32'hDEAD_BEEF);
        expect_both(16'h0000, 32'h1234_5670, "R2 iop write to req ignored");

        // R3 reply pointer, owned by iop
        i_write(16'h0008, 32'h0ABC_DEF0);
        expect_rd(0, 16'h0008, 32'h0ABC_DEF0, "R3 iop loads reply");
        h_write(16'h0008, 32'hFFFF_FFFF);
        expect_rd(1, 16'h0008, 32'h0ABC_DEF0, "R3 host write to reply ignored");

        // R4 / R7 host rings request doorbell
        h_write(16'h0004, 32'h1);
        expect_irqs(0, 1, "R7 irq_to_iop after request bit");
        expect_rd(1, 16'h0004, 32'h1, "R4 request bit set");
        h_write(16'h0004, 32'h0);
        expect_rd(0, 16'h0004, 32'h1, "R4 writing zero leaves bits");

        // R8 iop signals completion with 0x14
        i_write(16'h0004, 32'h14);
        expect_rd(0, 16'h0004, 32'h15, "R4 reply pattern set");
        expect_irqs(1, 1, "R8 irq_to_host on reply");

        // R5 acknowledges by write-1-to-clear
        i_write(16'h0004, 32'h1);
        expect_rd(1, 16'h0004, 32'h14, "R5 iop clears request bit");
        expect_irqs(1, 0, "R7 irq_to_iop drops");
        h_write(16'h0004, 32'h04);
        expect_rd(0, 16'h0004, 32'h10, "R5 host clears bit 2");
        expect_irqs(1, 0, "R8 irq_to_host held by bit 4");
        h_write(16'h0004, 32'h10);
        expect_irqs(0, 0, "R8 irq_to_host drops");

        // R5 owner cannot clear own bits
        h_write(16'h0004, 32'h8000_0101);
        h_write(16'h0004, 32'h8000_0101);
        expect_rd(0, 16'h0004, 32'h8000_0101, "R5 host rewrite keeps own bits");
        i_write(16'h0004, 32'h14);
        i_write(16'h0004, 32'h14);
        expect_rd(1, 16'h0004, 32'h8000_0115, "R5 iop rewrite keeps own bits");
        i_write(16'h0004, 32'h8000_0101);
        h_write(16'h0004, 32'h14);
        expect_rd(0, 16'h0004, 32'h0, "R5 cross clears to zero");

        // R6 same-cycle merge, set wins
        both_write(32'h05, 32'h05);
        expect_rd(0, 16'h0004, 32'h05, "R6 opposing set and clear, sets win");
        both_write(32'h10, 32'h10);
        expect_rd(1, 16'h0004, 32'h15, "R6 set wins on bit 4");
        both_write(32'h14, 32'h01);
        expect_rd(0, 16'h0004, 32'h0, "R6 both clear");
        both_write(32'h02, 32'h04);
        expect_rd(1, 16'h0004, 32'h06, "R6 disjoint sets merged");
        expect_irqs(1, 0, "R6 irqs after merge");

        // R9 decode window
        expect_rd(0, 16'h0404, 32'h06, "R9 mirror read of flags");
        h_write(16'h0C00, 32'h0000_55AA);
        expect_rd(1, 16'h0000, 32'h0000_55AA, "R9 mirror write to req");
        expect_rd(0, 16'h0003, 32'h0000_55AA, "R9 byte bits ignored");
        expect_rd(0, 16'h8008, 32'h0ABC_DEF0, "R9 upper address bits ignored");
        h_write(16'h000C, 32'hFFFF_FFFF);
        i_write(16'h03F0, 32'hFFFF_FFFF);
        expect_rd(0, 16'h000C, 32'h0, "R9 unmapped reads zero");
        expect_rd(1, 16'h03F0, 32'h0, "R9 unmapped reads zero iop");
        expect_rd(0, 16'h0004, 32'h06, "R9 unmapped write left flags");
        expect_rd(1, 16'h0000, 32'h0000_55AA, "R9 unmapped write left req");

        // R10 reads without side effect
        expect_both(16'h0004, 32'h06, "R10 both ports read flags");
        expect_both(16'h0004, 32'h06, "R10 repeated read unchanged");
        expect_both(16'h0008, 32'h0ABC_DEF0, "R10 both ports read reply");
        expect_irqs(1, 0, "R10 irqs unchanged by reads");

        drive(0, 0, '0, '0, 0, 0, '0, '0);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule